// File: doc/BRIEF.md
# Multi-channel timestamp compare event unit

This block watches a free-running 64-bit timestamp counter with sixteen independent compare channels. When an enabled channel's active compare value equals the counter, the channel raises a one-clock pulse, sets a sticky status bit whose level is also driven out, and contributes to a single global event line meant for an interrupt controller. A hit on channel 0 can also ask the counter to restart, which is how a periodic timebase is built.

Compare values are written as 32-bit halves. In direct mode a write lands in the active register at once. In shadow mode it is staged, and the active register is reloaded only when the counter signals a restart or wrap, so a PWM-style period can be retuned without a glitch. Status bits are cleared by write-1 strobes. An optional self-clear mode drops all of them on each counter restart instead.

Top module: `cmp_event_unit`

## Requirements
- R1: When channel i is enabled and its active compare value equals `count_i` at a rising edge, `pulse_o[i]` is high for the following clock cycle. It is low after any edge without such a match.
- R2: A channel whose `ch_en_i` bit is 0 at the edge produces no pulse and does not set its status bit, even when its value matches.
- R3: A hit sets `status_o[i]`. The bit stays set until a clear, and `level_o[i]` always equals `status_o[i]`.
- R4: A 1 in `clr_i[i]` clears `status_o[i]` from the next cycle on. Bits of `clr_i` that are 0 leave their status unchanged.
- R5: If a clear and a hit reach the same channel at the same edge, the status bit ends up set.
- R6: `global_o` is high in exactly the cycles in which at least one `pulse_o` bit is high.
- R7: `cnt_rst_req_o` is high for one cycle after a channel-0 hit when `ch0_rst_en_i` was 1 at that edge. It is never high otherwise.
- R8: With `shadow_en_i` = 0, a write (`wr_i`, channel `wr_ch_i`, `wr_hi_i` = 0 for bits 31:0 and 1 for bits 63:32) changes the active value from the next edge on. The other half is kept.
- R9: With `shadow_en_i` = 1, a write changes only the staged value. At an edge where `cnt_wrap_i` is 1, the active value takes the staged value as it was before that edge.
- R10: With `autoclr_en_i` = 1, an edge with `cnt_wrap_i` = 1 clears every status bit except those hit at that edge. Without `autoclr_en_i`, `cnt_wrap_i` leaves status unchanged.
- R11: After reset, all outputs are 0 and every compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Running timestamp counter value |
| cnt_wrap_i | input | 1 | Counter restarted or wrapped this cycle |
| ch_en_i | input | 16 | Per-channel compare enable |
| ch0_rst_en_i | input | 1 | Allow channel 0 hit to request counter reset |
| shadow_en_i | input | 1 | Stage compare writes until counter wrap |
| autoclr_en_i | input | 1 | Clear status bits on counter wrap |
| wr_i | input | 1 | Compare value write strobe |
| wr_ch_i | input | 4 | Channel addressed by the write |
| wr_hi_i | input | 1 | 0: bits 31:0, 1: bits 63:32 |
| wr_data_i | input | 32 | Write data for the selected half |
| clr_i | input | 16 | Write-1-to-clear status strobes |
| status_o | output | 16 | Sticky hit status per channel |
| level_o | output | 16 | Level event per channel |
| pulse_o | output | 16 | One-cycle event per channel |
| global_o | output | 1 | Any-channel event |
| cnt_rst_req_o | output | 1 | Counter reset request from channel 0 |

## Verification
The status bit of a channel has two writers that can act at the same edge: a new hit and a clear. The clear comes either from the `clr_i` strobe or from self-clear on a counter wrap. The bench provokes both collisions by holding the counter at the channel's compare value in the same cycle that it raises the clear strobe, and again in the same cycle that it raises `cnt_wrap_i` with self-clear on. The scoreboard's model lets the hit override the clear, and it expects the status and level bits to remain set while the pulse still fires. A third collision, a shadow write landing on the reload edge, is judged against the rule that the reload takes the staged value from before the edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;

  // Replace one half of a compare value, keeping the other half.
  function automatic logic [CNT_W-1:0] merge_half(
    input logic [CNT_W-1:0]  cur,
    input logic [HALF_W-1:0] data,
    input logic              hi
  );
    logic [CNT_W-1:0] r;
    r = cur;
    if (hi) r[CNT_W-1:HALF_W] = data;
    else    r[HALF_W-1:0]     = data;
    return r;
  endfunction

  // Equality test between a compare value and the counter.
  function automatic logic is_match(
    input logic             en,
    input logic [CNT_W-1:0] value,
    input logic [CNT_W-1:0] count
  );
    return en && (value == count);
  endfunction
endpackage

// File: rtl/cmp_value_reg.sv
module cmp_value_reg
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              hi_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic              shadow_mode_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  active_o
);
  logic [CNT_W-1:0] staged_q;
  logic [CNT_W-1:0] active_q;
  logic             direct_wr;
  logic             reload;

  assign direct_wr = wr_i && !shadow_mode_i;
  assign reload    = shadow_mode_i && load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i) staged_q <= merge_half(staged_q, data_i, hi_i);
      if (direct_wr)   active_q <= merge_half(active_q, data_i, hi_i);
      else if (reload) active_q <= staged_q;
    end
  end

  assign active_o = active_q;

  // R9: staged writes never disturb the active value before a reload
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mode_i && !load_i) |=> $stable(active_o));

  // R8: direct low-half write visible at the next edge
  a_r8_direct_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !shadow_mode_i && !hi_i) |=> (active_o[HALF_W-1:0] == $past(data_i)));

  // R8: direct high-half write visible at the next edge
  a_r8_direct_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !shadow_mode_i && hi_i) |=> (active_o[CNT_W-1:HALF_W] == $past(data_i)));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  input  logic             autoclr_i,
  input  logic             wrap_i,
  output logic             hit_o,
  output logic             status_o,
  output logic             pulse_o
);
  logic status_q;
  logic pulse_q;
  logic drop;

  assign hit_o = is_match(en_i, value_i, count_i);
  assign drop  = clr_i || (autoclr_i && wrap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      status_q <= (status_q && !drop) || hit_o;
      pulse_q  <= hit_o;
    end
  end

  assign status_o = status_q;
  assign pulse_o  = pulse_q;

  // R1: a match is followed by the pulse
  a_r1_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> pulse_o);

  // R2: disabled channel never pulses
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pulse_o);

  // R3: status is sticky without a clear source
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !clr_i && !(autoclr_i && wrap_i)) |=> status_o);

  // R4: clear without a hit empties the bit
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_o) |=> !status_o);

  // R5: a hit always leaves the status set, even against a clear
  a_r5_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> status_o);
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_pkg::*;
#(
  parameter int N_CH = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              cnt_wrap_i,
  input  logic [N_CH-1:0]   ch_en_i,
  input  logic              ch0_rst_en_i,
  input  logic              shadow_en_i,
  input  logic              autoclr_en_i,
  input  logic              wr_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic [N_CH-1:0]   clr_i,
  output logic [N_CH-1:0]   status_o,
  output logic [N_CH-1:0]   level_o,
  output logic [N_CH-1:0]   pulse_o,
  output logic              global_o,
  output logic              cnt_rst_req_o
);
  logic [N_CH-1:0] hit;
  logic            global_q;
  logic            rst_req_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CNT_W-1:0] active;
    logic             sel;

    assign sel = wr_i && (wr_ch_i == CH_W'(g));

    cmp_value_reg u_val (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_i          (sel),
      .hi_i          (wr_hi_i),
      .data_i        (wr_data_i),
      .shadow_mode_i (shadow_en_i),
      .load_i        (cnt_wrap_i),
      .active_o      (active)
    );

    cmp_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ch_en_i[g]),
      .value_i   (active),
      .count_i   (count_i),
      .clr_i     (clr_i[g]),
      .autoclr_i (autoclr_en_i),
      .wrap_i    (cnt_wrap_i),
      .hit_o     (hit[g]),
      .status_o  (status_o[g]),
      .pulse_o   (pulse_o[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      global_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      global_q  <= |hit;
      rst_req_q <= hit[0] && ch0_rst_en_i;
    end
  end

  assign level_o       = status_o;
  assign global_o      = global_q;
  assign cnt_rst_req_o = rst_req_q;

  // R6: global event tracks the channel pulses
  a_r6_global: assert property (@(posedge clk) disable iff (!rst_n)
    global_o == (|pulse_o));

  // R7: reset request only accompanies a channel 0 pulse
  a_r7_req_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_req_o |-> pulse_o[0]);

  // R7: no request while the enable is off
  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ch0_rst_en_i |=> !cnt_rst_req_o);
endmodule

// File: tb/cmp_event_unit_bench.sv
module cmp_event_unit_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = 64'hFFFF_0000;
  logic        wrap = 1'b0;
  logic [N-1:0] en = '0;
  logic        rst_en = 1'b0;
  logic        shadow = 1'b0;
  logic        autoclr = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  wr_ch = '0;
  logic        wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] clr = '0;
  logic [N-1:0] status, level, pulse;
  logic        glob, rreq;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cmp_event_unit u_cmp_event_unit (
    .clk(clk), .rst_n(rst_n), .count_i(count), .cnt_wrap_i(wrap),
    .ch_en_i(en), .ch0_rst_en_i(rst_en), .shadow_en_i(shadow),
    .autoclr_en_i(autoclr), .wr_i(wr), .wr_ch_i(wr_ch), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .clr_i(clr), .status_o(status), .level_o(level),
    .pulse_o(pulse), .global_o(glob), .cnt_rst_req_o(rreq)
  );

  typedef struct {
    logic [N-1:0] e_pulse;
    logic [N-1:0] e_status;
    logic         e_glob;
    logic         e_rreq;
    string        tag;
  } exp_t;

  exp_t q[$];

  // Bench-side model of the compare values and status
  logic [63:0]  m_act [N];
  logic [63:0]  m_stg [N];
  logic [N-1:0] m_status = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: model the edge, push expectation, advance one cycle
  task automatic step(input string tag);
    exp_t it;
    logic [N-1:0] h;
    logic [N-1:0] keep;
    for (int i = 0; i < N; i++) h[i] = en[i] && (m_act[i] == count);
    keep = ~clr & ((autoclr && wrap) ? '0 : {N{1'b1}});
    m_status = (m_status & keep) | h;
    it.e_pulse  = h;
    it.e_status = m_status;
    it.e_glob   = |h;
    it.e_rreq   = h[0] && rst_en;
    it.tag      = tag;
    q.push_back(it);
    for (int i = 0; i < N; i++) begin
      logic [63:0] old_stg;
      old_stg = m_stg[i];
      if (wr && wr_ch == 4'(i)) begin
        if (wr_hi) m_stg[i][63:32] = wr_data; else m_stg[i][31:0] = wr_data;
        if (!shadow) begin
          if (wr_hi) m_act[i][63:32] = wr_data; else m_act[i][31:0] = wr_data;
        end
      end
      if (shadow && wrap && !(wr && wr_ch == 4'(i) && !shadow)) m_act[i] = old_stg;
    end
    @(negedge clk);
    wr = 1'b0; clr = '0; wrap = 1'b0;
  endtask

  task automatic write(input int ch, input logic hi, input logic [31:0] d, input string tag);
    wr = 1'b1; wr_ch = 4'(ch); wr_hi = hi; wr_data = d;
    step(tag);
  endtask

  // Monitor: sample away from the edge and compare in order
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " pulse"},  64'(pulse),  64'(it.e_pulse));
        check({it.tag, " status"}, 64'(status), 64'(it.e_status));
        check({it.tag, " level"},  64'(level),  64'(it.e_status));
        check({it.tag, " global"}, 64'(glob),   64'(it.e_glob));
        check({it.tag, " rstreq"}, 64'(rreq),   64'(it.e_rreq));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_act[i] = '0; m_stg[i] = '0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 status", 64'(status), 0);
    check("R11 pulse",  64'(pulse),  0);
    check("R11 global", 64'(glob),   0);
    check("R11 rstreq", 64'(rreq),   0);
    rst_n = 1'b1;
    @(negedge clk);
    count = 64'd0; en = 16'hFFFF;
    step("R11 zero values match");          // all values reset to 0
    en = '0; clr = 16'hFFFF; count = 64'd500;
    step("R4 clear all");
    // R8 direct writes
    write(3, 1'b0, 32'd10, "R8 write ch3");
    write(5, 1'b0, 32'd10, "R8 write ch5");
    en[3] = 1'b1; count = 64'd10;
    step("R1 R2 ch3 hit ch5 disabled");
    count = 64'd11;
    step("R3 status sticky");
    clr = 16'h0010; count = 64'd12;
    step("R4 clear other bit no effect");
    clr = 16'h0008;
    step("R4 clear ch3");
    clr = 16'h0008; count = 64'd10;
    step("R5 hit beats clear");
    // R6: two channels at once
    write(7, 1'b0, 32'd10, "R8 write ch7");
    en[7] = 1'b1;
    step("R6 two hits");
    count = 64'd13;
    step("R6 quiet");
    // R7: channel 0 reset request
    write(0, 1'b0, 32'd30, "R8 write ch0");
    en[0] = 1'b1; rst_en = 1'b1; count = 64'd30;
    step("R7 request");
    count = 64'd31;
    step("R7 one cycle");
    rst_en = 1'b0; count = 64'd30;
    step("R7 gated off");
    // R8: high half
    write(2, 1'b0, 32'd5, "R8 lo half");
    write(2, 1'b1, 32'd1, "R8 hi half");
    en[2] = 1'b1; count = 64'h0000_0001_0000_0005;
    step("R8 64-bit match");
    count = 64'd5;
    step("R8 low half alone no match");
    // R9: shadow mode
    shadow = 1'b1; en[4] = 1'b1;
    write(4, 1'b0, 32'd40, "R9 staged write");
    count = 64'd40;
    step("R9 no hit before reload");
    wrap = 1'b1; count = 64'd77;
    write(4, 1'b0, 32'd41, "R9 write on reload edge");
    count = 64'd40;
    step("R9 reloaded old staged value");
    count = 64'd41;
    step("R9 new staged not active");
    wrap = 1'b1; count = 64'd78;
    step("R9 second reload");
    count = 64'd41;
    step("R9 after second reload");
    shadow = 1'b0;
    // R10: self-clear
    count = 64'd10;
    step("R10 set ch3 ch7");
    wrap = 1'b1; count = 64'd90;
    step("R10 wrap without autoclr keeps");
    autoclr = 1'b1; wrap = 1'b1;
    step("R10 autoclr clears");
    wrap = 1'b1; count = 64'd10;
    step("R10 hit beats autoclr");
    count = 64'd91;
    step("R10 no wrap keeps");
    autoclr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule